// File: doc/BRIEF.md
# NAND Page and Block Storage Engine

This block is the storage core that sits behind a NAND-style command front end. It holds a linear byte array of pages. Each page of `PAGE_BYTES` data bytes is followed at once by its spare area, one thirty-second of the page. The front end hands it one request at a time. A request programs bytes from a caller-side source buffer, erases one erase block, or loads the rest of a page (data plus spare) into a caller-side destination buffer.

The engine moves one byte per clock. It reads the source buffer through an index and data pair, and writes the destination buffer through a write strobe with index and data. When the work ends it raises `done` for a single cycle. A load also returns the address that the front end should keep for sequential reading. After reset the engine first fills the whole array with FFh and holds `reqReady` low until that fill has finished.

The page size (256, 512 or 2048) and the pages-per-block exponent are parameters. The page index is the address shifted right by 8 for the two small page sizes and by 16 for 2048-byte pages. The column is the low bits below that shift.

Top module: `nand_store_engine`

## Requirements
- R1: After reset `reqReady` stays low while every byte of the array is set to FFh. It then goes high, and a load of any in-range page returns only FFh.
- R2: Program (op code 0) writes `reqLen` bytes, source byte i going to array position pageIndex*(page+spare) + column + `reqExtra` + i. Each byte replaces the old contents outright. A write that would pass the end of the array is cut off there.
- R3: The spare area is page size >> 5 bytes and lies directly after its page data. The page index is the address >> 8 for 256- and 512-byte pages and >> 16 for 2048-byte pages. The column is the address bits below that shift.
- R4: Load (op code 2) copies array bytes from page start + column up to the end of that page's spare area into destination indices 0, 1, 2, and so on. That is (page+spare) − column bytes, or none when the column is past the spare end.
- R5: After an in-range load, `addrOut` holds (address mod page size) + page size. After any other request, `addrOut` holds the request address unchanged.
- R6: Erase (op code 1) clears the low (address shift + block exponent) address bits. It then writes FFh over (page+spare) << block exponent bytes starting at that block's first page, cut off at the array end. Pages of other blocks keep their contents.
- R7: A program, erase or load whose page index (for erase, the aligned block's first page) is at or beyond `NUM_PAGES` changes no array byte and writes no destination byte. It still completes with `done`.
- R8: `done` is a one-cycle pulse. It rises exactly N clock edges after the edge that accepts the request, N being the number of bytes moved (0 for requests that move nothing).
- R9: A request is accepted only on an edge where `reqReady` is high. `reqReady` is low from the accepting edge until the cycle after `done`.
- R10: Op code 3 moves no byte and changes no state except `addrOut`, which follows R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; starts the FFh fill |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 0 program, 1 erase, 2 load, 3 no operation |
| reqAddr | input | ADDR_W | Request address (page index and column) |
| reqLen | input | LEN_W | Program byte count |
| reqExtra | input | LEN_W | Extra offset added to the program target |
| reqReady | output | 1 | Engine idle; a request is taken on this edge if reqValid |
| srcIdx | output | LEN_W | Index into the caller's source buffer |
| srcData | input | 8 | Source byte at srcIdx, combinational from the caller |
| dstWe | output | 1 | Destination buffer write strobe (load) |
| dstIdx | output | LEN_W | Destination buffer index |
| dstData | output | 8 | Destination buffer byte |
| done | output | 1 | One-cycle completion pulse |
| addrOut | output | ADDR_W | Follow-on address after a request (see R5) |

## Verification
Two cases are hard to reach from the ports: the erase of the last, partly populated block, and a program whose target runs off the end of the array. Both can only be seen through the cut-off byte count and through later loads of neighbouring pages. The directed part fills the last pages with known data, erases the final block and a lower block by addresses that carry non-zero column and in-block page bits, and programs near the array end. Completion timing is then compared with the clipped count, and the surrounding pages are read back. A seeded random mix of programs, erases and loads, including page indices past the array, then runs against a byte model kept in the bench.

// File: rtl/nand_store_pkg.sv
package nand_store_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_LOAD  = 2'd2,
    OP_NOP   = 2'd3
  } opE;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the request and its computed window
    logic step;     // move one byte and advance the window
  } strobeT;

endpackage

// File: rtl/nand_store_ctrl.sv
module nand_store_ctrl
  import nand_store_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   startEmpty,
  input  logic   lastByte,
  output strobeT strb,
  output logic   reqReady,
  output logic   done
);

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_RUN, S_FIN} stateE;
  stateE state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      S_INIT: begin
        strb.step = 1'b1;
        if (lastByte) stateNext = S_IDLE;
      end
      S_IDLE: begin
        if (reqValid) begin
          strb.capture = 1'b1;
          stateNext    = startEmpty ? S_FIN : S_RUN;
        end
      end
      S_RUN: begin
        strb.step = 1'b1;
        if (lastByte) stateNext = S_FIN;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_INIT;
    else       state <= stateNext;
  end

  assign reqReady = (state == S_IDLE);
  assign done     = (state == S_FIN);

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: an accepted request makes the engine busy on the next cycle
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/nand_store_dp.sv
module nand_store_dp
  import nand_store_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int BLOCK_SHIFT = 4,
  parameter int NUM_PAGES   = 18,
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 9
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [LEN_W-1:0]  reqExtra,
  output logic              startEmpty,
  output logic              lastByte,
  output logic [LEN_W-1:0]  srcIdx,
  input  logic [7:0]        srcData,
  output logic              dstWe,
  output logic [LEN_W-1:0]  dstIdx,
  output logic [7:0]        dstData,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int ADDR_SHIFT = (PAGE_BYTES == 2048) ? 16 : 8;
  localparam int SPARE      = PAGE_BYTES >> 5;
  localparam int STRIDE     = PAGE_BYTES + SPARE;
  localparam int TOTAL      = NUM_PAGES * STRIDE;
  localparam int PTR_W      = $clog2(TOTAL);
  localparam int CNT_W      = $clog2(TOTAL + 1);

  localparam logic [31:0] STRIDE32 = 32'(STRIDE);
  localparam logic [31:0] TOTAL32  = 32'(TOTAL);
  localparam logic [31:0] NPAGE32  = 32'(NUM_PAGES);
  localparam logic [31:0] PAGE32   = 32'(PAGE_BYTES);
  localparam logic [31:0] COLMASK  = (32'd1 << ADDR_SHIFT) - 32'd1;
  localparam logic [31:0] BLKMASK  = (32'd1 << (ADDR_SHIFT + BLOCK_SHIFT)) - 32'd1;
  localparam logic [31:0] BLKBYTES = STRIDE32 << BLOCK_SHIFT;

  logic [7:0] mem [TOTAL];

  // request decode: window start, byte count, follow-on address
  logic [31:0] addr32, pageIdx, col, blkPage, winStart, winRaw, winCnt;
  logic        inRange;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    addr32   = 32'(reqAddr);
    pageIdx  = addr32 >> ADDR_SHIFT;
    col      = addr32 & COLMASK;
    blkPage  = (addr32 & ~BLKMASK) >> ADDR_SHIFT;
    inRange  = 1'b0;
    winStart = '0;
    winRaw   = '0;
    nextAddr = reqAddr;
    case (opE'(reqOp))
      OP_PROG: begin
        inRange  = pageIdx < NPAGE32;
        winStart = pageIdx * STRIDE32 + col + 32'(reqExtra);
        winRaw   = 32'(reqLen);
      end
      OP_ERASE: begin
        inRange  = blkPage < NPAGE32;
        winStart = blkPage * STRIDE32;
        winRaw   = BLKBYTES;
      end
      OP_LOAD: begin
        inRange  = pageIdx < NPAGE32;
        winStart = pageIdx * STRIDE32 + col;
        winRaw   = (col < STRIDE32) ? (STRIDE32 - col) : 32'd0;
        if (inRange) nextAddr = ADDR_W'((addr32 & (PAGE32 - 32'd1)) + PAGE32);
      end
      default: ;
    endcase
    if (!inRange || winStart >= TOTAL32) winCnt = '0;
    else if (winRaw > TOTAL32 - winStart) winCnt = TOTAL32 - winStart;
    else winCnt = winRaw;
  end

  assign startEmpty = (winCnt == 32'd0);

  // byte window state
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] remain;
  logic [LEN_W-1:0] idx;
  logic             wrMem, wrFill, rdOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      remain  <= CNT_W'(TOTAL);
      idx     <= '0;
      wrMem   <= 1'b1;
      wrFill  <= 1'b1;
      rdOut   <= 1'b0;
      addrOut <= '0;
    end else if (strb.capture) begin
      ptr     <= PTR_W'(winStart);
      remain  <= CNT_W'(winCnt);
      idx     <= '0;
      wrMem   <= (reqOp == OP_PROG) || (reqOp == OP_ERASE);
      wrFill  <= (reqOp == OP_ERASE);
      rdOut   <= (reqOp == OP_LOAD);
      addrOut <= nextAddr;
    end else if (strb.step) begin
      ptr    <= ptr + PTR_W'(1);
      remain <= remain - CNT_W'(1);
      idx    <= idx + LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.step && wrMem) mem[ptr] <= wrFill ? 8'hFF : srcData;
  end

  assign lastByte = (remain == CNT_W'(1));
  assign srcIdx   = idx;
  assign dstIdx   = idx;
  assign dstWe    = strb.step && rdOut;
  assign dstData  = mem[ptr];

  // R8: control never steps an exhausted window
  p_step_work_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (remain != '0));

  // R3: every moved byte lies inside the array
  p_ptr_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (32'(ptr) < TOTAL32));

  // R4: load output index stays within one page plus spare
  p_dst_idx_r4: assert property (@(posedge clk) disable iff (!rstN)
    dstWe |-> (32'(dstIdx) < STRIDE32));

endmodule

// File: rtl/nand_store_engine.sv
module nand_store_engine
  import nand_store_pkg::*;
#(
  parameter int PAGE_BYTES  = 256,
  parameter int BLOCK_SHIFT = 4,
  parameter int NUM_PAGES   = 18,
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = $clog2(PAGE_BYTES + (PAGE_BYTES >> 5) + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [LEN_W-1:0]  reqExtra,
  output logic              reqReady,
  output logic [LEN_W-1:0]  srcIdx,
  input  logic [7:0]        srcData,
  output logic              dstWe,
  output logic [LEN_W-1:0]  dstIdx,
  output logic [7:0]        dstData,
  output logic              done,
  output logic [ADDR_W-1:0] addrOut
);

  strobeT strb;
  logic   startEmpty, lastByte;

  nand_store_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .startEmpty(startEmpty), .lastByte(lastByte),
    .strb(strb), .reqReady(reqReady), .done(done)
  );

  nand_store_dp #(
    .PAGE_BYTES(PAGE_BYTES), .BLOCK_SHIFT(BLOCK_SHIFT), .NUM_PAGES(NUM_PAGES),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen), .reqExtra(reqExtra),
    .startEmpty(startEmpty), .lastByte(lastByte),
    .srcIdx(srcIdx), .srcData(srcData),
    .dstWe(dstWe), .dstIdx(dstIdx), .dstData(dstData),
    .addrOut(addrOut)
  );

endmodule

// File: tb/nand_store_engine_tb_top.sv
`timescale 1ns/1ps
module nand_store_engine_tb_top;

  localparam int STR   = 264;
  localparam int NP    = 18;
  localparam int TOTAL = NP * STR;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [23:0] reqAddr = '0;
  logic [8:0]  reqLen = '0, reqExtra = '0;
  logic        reqReady, dstWe, done;
  logic [8:0]  srcIdx, dstIdx;
  logic [7:0]  srcData, dstData;
  logic [23:0] addrOut;

  logic [7:0] srcBuf [512];
  logic [7:0] dstBuf [512];
  logic [7:0] model  [TOTAL];
  int dstCnt = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign srcData = srcBuf[srcIdx];

  always @(posedge clk) if (dstWe) begin
    dstBuf[dstIdx] <= dstData;
    dstCnt <= dstCnt + 1;
  end

  nand_store_engine dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqExtra(reqExtra),
    .reqReady(reqReady), .srcIdx(srcIdx), .srcData(srcData),
    .dstWe(dstWe), .dstIdx(dstIdx), .dstData(dstData),
    .done(done), .addrOut(addrOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected window from the requirements
  task automatic expect_op(input int op, input logic [23:0] a, input int len, input int extra,
                           output int st, output int cnt, output logic [23:0] na);
    int pg, col, bp;
    pg = int'(a >> 8); col = int'(a & 24'hFF); bp = int'((a & ~24'hFFF) >> 8);
    st = 0; cnt = 0; na = a;
    case (op)
      0: if (pg < NP) begin st = pg * STR + col + extra; cnt = len; end
      1: if (bp < NP) begin st = bp * STR; cnt = STR * 16; end
      2: if (pg < NP) begin
           st = pg * STR + col; cnt = (col < STR) ? STR - col : 0;
           na = (a & 24'hFF) + 24'd256;
         end
      default: ;
    endcase
    if (cnt > 0) begin
      if (st >= TOTAL) cnt = 0;
      else if (cnt > TOTAL - st) cnt = TOTAL - st;
    end
  endtask

  task automatic do_op(input int op, input logic [23:0] a, input int len, input int extra,
                       input string tag);
    int st, cnt, k, d0, bad, firstBad;
    logic [23:0] na;
    expect_op(op, a, len, extra, st, cnt, na);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqAddr = a; reqLen = 9'(len); reqExtra = 9'(extra);
    d0 = dstCnt;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, {tag, " R9 busy after accept"}, int'(reqReady), 0);
    k = 0;
    while (!done && k < 6000) begin @(negedge clk); k++; end
    chk(k == cnt, {tag, " R8 done latency"}, k, cnt);
    chk(addrOut == na, {tag, " R5 addrOut"}, int'(addrOut), int'(na));
    @(negedge clk);
    chk(!done, {tag, " R8 done single pulse"}, int'(done), 0);
    case (op)
      0: for (int i = 0; i < cnt; i++) model[st + i] = srcBuf[i];
      1: for (int i = 0; i < cnt; i++) model[st + i] = 8'hFF;
      default: ;
    endcase
    chk(dstCnt - d0 == ((op == 2) ? cnt : 0), {tag, " R4/R7 dst writes"}, dstCnt - d0,
        (op == 2) ? cnt : 0);
    if (op == 2) begin
      bad = 0; firstBad = -1;
      for (int i = 0; i < cnt; i++)
        if (dstBuf[i] !== model[st + i]) begin bad++; if (firstBad < 0) firstBad = i; end
      chk(bad == 0, {tag, " R4 load data"},
          (firstBad < 0) ? 0 : int'(dstBuf[firstBad]),
          (firstBad < 0) ? 0 : int'(model[st + firstBad]));
    end
  endtask

  task automatic fill_src(input int pattern);
    for (int i = 0; i < 512; i++)
      case (pattern)
        0: srcBuf[i] = 8'h00;
        1: srcBuf[i] = 8'hA5;
        default: srcBuf[i] = 8'($urandom);
      endcase
  endtask

  function automatic logic [23:0] mkAddr(input int pg, input int col);
    return 24'((pg << 8) | (col & 255));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < TOTAL; i++) model[i] = 8'hFF;
    fill_src(2);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!reqReady, "R1 ready low during fill", int'(reqReady), 0);
    // R1: fresh array reads back FFh
    do_op(2, mkAddr(0, 0), 0, 0, "R1 load after reset");
    do_op(2, mkAddr(17, 0), 0, 0, "R1 load last page");
    // R2 / R3: program into page 2 at a column
    fill_src(2);
    do_op(0, mkAddr(2, 5), 20, 0, "R2 program page2");
    do_op(2, mkAddr(2, 0), 0, 0, "R3 readback page2");
    // R2: direct overwrite, no AND with old contents
    fill_src(0);
    do_op(0, mkAddr(4, 0), 32, 0, "R2 program zeros");
    fill_src(1);
    do_op(0, mkAddr(4, 0), 32, 0, "R2 overwrite A5");
    do_op(2, mkAddr(4, 0), 0, 0, "R2 overwrite readback");
    // R3: extra offset of one page reaches the spare area
    fill_src(2);
    do_op(0, mkAddr(3, 0), 8, 256, "R3 program spare");
    do_op(2, mkAddr(3, 200), 0, 0, "R4 R5 load col200");
    // R6: data beyond block 0 survives a block 0 erase
    fill_src(2);
    do_op(0, mkAddr(16, 10), 40, 0, "R6 program page16");
    do_op(1, mkAddr(5, 7), 0, 0, "R6 erase block0 unaligned");
    do_op(2, mkAddr(3, 0), 0, 0, "R6 page3 erased");
    do_op(2, mkAddr(16, 0), 0, 0, "R6 page16 kept");
    // R6: last block clipped at array end
    do_op(1, mkAddr(17, 100), 0, 0, "R6 erase last block");
    do_op(2, mkAddr(16, 0), 0, 0, "R6 page16 erased");
    // R2: program running off the array end is cut off
    fill_src(2);
    do_op(0, mkAddr(17, 250), 100, 0, "R2 clip at end");
    do_op(2, mkAddr(17, 240), 0, 0, "R2 clip readback");
    // R7: out of range requests
    fill_src(2);
    do_op(0, mkAddr(20, 0), 50, 0, "R7 program oob");
    do_op(2, mkAddr(18, 3), 0, 0, "R7 load oob");
    do_op(1, mkAddr(40, 0), 0, 0, "R7 erase oob");
    // R10: no-operation code
    do_op(3, mkAddr(1, 9), 10, 0, "R10 nop");
    do_op(2, mkAddr(1, 0), 0, 0, "R10 page1 untouched");
    // seeded random mix
    for (int n = 0; n < 50; n++) begin
      int op, pg, col, len, ex;
      op  = int'($urandom % 4);
      pg  = int'($urandom % 21);
      col = int'($urandom % 256);
      len = int'($urandom % 265);
      ex  = ($urandom % 4 == 0) ? 256 : 0;
      if (op == 1 && ($urandom % 3) != 0) op = 2;
      fill_src(2);
      do_op(op, mkAddr(pg, col), len, ex, "R2 R4 R6 random");
      if (op != 2) do_op(2, mkAddr(pg % NP, 0), 0, 0, "R4 random readback");
    end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule